// File: doc/BRIEF.md
# Power, Interrupt and Clock Control Unit

This unit owns a single 16-bit control/status word at a fixed I/O address. The word sets the direction of four port pin groups, holds a five-bit external memory configuration, and holds the CPU clock controls: run/stop, full-speed or divide-by-N, and power-down. A clock divider turns the clock fields into a per-cycle CPU clock enable.

The unit also watches the keyboard column inputs and one port pin, which it treats as active-low contacts. A power-state machine with the states `PWR_RUN`, `PWR_OFF_WAIT`, `PWR_OFF_HOLD` and `PWR_RESET` reads the column inputs and drives power-off, CPU reset and halt requests.

- `PWR_RUN` moves to `PWR_OFF_WAIT` when the off pair is pressed.
- `PWR_OFF_WAIT` moves to `PWR_OFF_HOLD` when an on pair is pressed.
- `PWR_OFF_HOLD` moves to `PWR_RESET` when that pair is released.
- `PWR_RESET` always moves back to `PWR_RUN` after one cycle.

A filtered low level on the watched pin sets a sticky capture flag and can raise an event interrupt. A release of any key column raises a wake pulse.

Top module: `pic_unit`

## Requirements
- R1: After reset the register reads 0x0C0F: bits 0-3 set, bit 10 (run) set, bit 11 (fast) set, all other bits clear. Bits 13-15 always read 0.
- R2: A write to address 0x0104 with bus_sel_i and bus_we_i high loads the following fields, which read back and appear on the outputs:
  - bits 0-3 give grp_dir_o, where 1 means input;
  - bits 5-9 give mem_cfg_o;
  - bit 10 gives clk_run_o;
  - bit 11 gives clk_fast_o;
  - bit 12 gives pwr_down_o.
- R3: Bit 4 is set when port_pin1_i is seen low on at least two consecutive synchronised samples. A single-sample low does not set it. Once set, it stays set until any register write clears it, whatever the written bit 4. A capture in the same cycle as the write wins.
- R4: When port_pin1_i becomes filtered-low (as in R3) while int_mask_i is 0, evt_req_o rises and stays high until evt_ack_i. When int_mask_i is 1, no request is raised.
- R5: In `PWR_RUN`, the onset of columns 9 and 10 both low, or of columns 0 and 10 both low, raises halt_req_o. It stays high until halt_ack_i.
- R6: Columns 0 and 1 both low enter power-off. power_off_o is then high and cpu_clk_en_o is 0. The unit stays off, with no halt request, until an on pair (R5) is pressed.
- R7: Releasing the held on pair gives exactly one cycle of cpu_reset_o and returns to running. The next on-pair press raises halt_req_o.
- R8: Any key column changing from 0 to 1 gives a one-cycle wake_o pulse.
- R9: cpu_clk_en_o behaves as follows:
  - it is never high when run is 0;
  - it is high every cycle when fast is 1;
  - it is high once per DIV_RATIO cycles when fast is 0.
- R10: Reads of any other address return 0, and writes to any other address leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |
| key_col_i | input | KEY_W | Keyboard column inputs, low when pressed |
| port_pin1_i | input | 1 | Watched port pin, asynchronous |
| int_mask_i | input | 1 | Event interrupt mask from the CPU status word |
| halt_ack_i | input | 1 | Clears halt_req_o |
| evt_ack_i | input | 1 | Clears evt_req_o |
| grp_dir_o | output | 4 | Pin group directions, 1 means input |
| mem_cfg_o | output | 5 | Memory configuration field |
| clk_run_o | output | 1 | CPU clock run bit |
| clk_fast_o | output | 1 | Full-speed select (0 means divide) |
| pwr_down_o | output | 1 | Power-down request bit |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| halt_req_o | output | 1 | Halt interrupt request |
| evt_req_o | output | 1 | Event interrupt request |
| power_off_o | output | 1 | Power-off state |
| cpu_reset_o | output | 1 | One-cycle CPU reset |
| wake_o | output | 1 | Wake-from-idle pulse |

## Verification
The bench uses the default parameters:
- KEY_W = 11;
- two synchroniser stages;
- a two-sample low filter;
- DIV_RATIO = 8.

With DIV_RATIO = 8, a 64-cycle window holds exactly eight slow enables. A two-sample filter lets a one-cycle pin pulse land just below the capture threshold. Eleven columns include both the off pair and both on pairs. Random register writes and random presses on the columns outside those pairs run alongside directed sequences through every power state.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        PWR_RUN      = 2'd0,
        PWR_OFF_WAIT = 2'd1,
        PWR_OFF_HOLD = 2'd2,
        PWR_RESET    = 2'd3
    } pwr_state_e;

    localparam int CSR_W      = 16;
    localparam int DIR_LSB    = 0;
    localparam int DIR_W      = 4;
    localparam int FLAG_BIT   = 4;
    localparam int MEM_LSB    = 5;
    localparam int MEM_W      = 5;
    localparam int RUN_BIT    = 10;
    localparam int FAST_BIT   = 11;
    localparam int PDN_BIT    = 12;

    localparam logic [CSR_W-1:0] CSR_RESET = 16'h0C0F;
    localparam logic [CSR_W-1:0] CSR_WMASK = 16'h1FEF;

    localparam int KEY_OFF_A = 0;
    localparam int KEY_OFF_B = 1;
    localparam int KEY_ON_A  = 9;
    localparam int KEY_ON_C  = 0;
    localparam int KEY_ON_B  = 10;

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int       W       = 1,
    parameter int       STAGES  = 2,
    parameter logic     RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= {W{RST_VAL}};
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pic_lowfilt.sv
module pic_lowfilt #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s_i,
    output logic low_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pin_s_i) begin
            run_q <= '0;
        end else if (run_q != FULL) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign low_o = (run_q == FULL);

    // A high sample ends any filtered-low stretch (R3)
    p_high_breaks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_s_i |=> !low_o);
endmodule

// File: rtl/pic_csr.sv
module pic_csr
    import pic_pkg::*;
#(
    parameter logic [15:0] CSR_ADDR = 16'h0104
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             we_i,
    input  logic [15:0]      addr_i,
    input  logic [CSR_W-1:0] wdata_i,
    input  logic             capture_i,
    output logic [CSR_W-1:0] rdata_o,
    output logic [CSR_W-1:0] csr_o
);
    logic [CSR_W-1:0] csr_q, csr_d;
    logic             hit, wr_hit;

    assign hit    = sel_i && (addr_i == CSR_ADDR);
    assign wr_hit = hit && we_i;

    always_comb begin
        csr_d           = wr_hit ? (wdata_i & CSR_WMASK) : csr_q;
        csr_d[FLAG_BIT] = (csr_q[FLAG_BIT] && !wr_hit) || capture_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= CSR_RESET;
        else        csr_q <= csr_d;
    end

    assign csr_o   = csr_q;
    assign rdata_o = hit ? csr_q : '0;

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q[FLAG_BIT] && !wr_hit) |=> csr_q[FLAG_BIT]);
    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !capture_i) |=> !csr_q[FLAG_BIT]);
    p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !capture_i && !csr_q[FLAG_BIT]) |=> $stable(csr_q));
endmodule

// File: rtl/pic_clkdiv.sv
module pic_clkdiv #(
    parameter int DIV_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    input  logic hold_i,
    output logic clk_en_o
);
    logic tick;

    generate
        if (DIV_RATIO <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV_RATIO);
            localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == LAST);

            // Slow ticks are never back to back (R9)
            p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

    assign clk_en_o = run_i && !hold_i && (fast_i || tick);
endmodule

// File: rtl/pic_pwr_fsm.sv
module pic_pwr_fsm
    import pic_pkg::*;
#(
    parameter int KEY_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_s_i,
    input  logic             halt_ack_i,
    output logic             halt_req_o,
    output logic             power_off_o,
    output logic             cpu_reset_o,
    output logic             wake_o
);
    pwr_state_e   state_q, state_d;
    logic         off_pair, on_pair, on_pair_q, halt_q, halt_set;
    logic [KEY_W-1:0] key_q;

    assign off_pair = !key_s_i[KEY_OFF_A] && !key_s_i[KEY_OFF_B];
    assign on_pair  = !key_s_i[KEY_ON_B] &&
                      (!key_s_i[KEY_ON_A] || !key_s_i[KEY_ON_C]);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:      if (off_pair) state_d = PWR_OFF_WAIT;
            PWR_OFF_WAIT: if (on_pair)  state_d = PWR_OFF_HOLD;
            PWR_OFF_HOLD: if (!on_pair) state_d = PWR_RESET;
            PWR_RESET:                  state_d = PWR_RUN;
            default:                    state_d = PWR_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    assign halt_set = (state_q == PWR_RUN) && on_pair && !on_pair_q && !off_pair;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_pair_q <= 1'b0;
            halt_q    <= 1'b0;
            key_q     <= '1;
        end else begin
            on_pair_q <= on_pair;
            key_q     <= key_s_i;
            if (halt_set)        halt_q <= 1'b1;
            else if (halt_ack_i) halt_q <= 1'b0;
        end
    end

    always_comb begin
        power_off_o = 1'b0;
        cpu_reset_o = 1'b0;
        unique case (state_q)
            PWR_RUN:      ;
            PWR_OFF_WAIT: power_off_o = 1'b1;
            PWR_OFF_HOLD: power_off_o = 1'b1;
            PWR_RESET:    cpu_reset_o = 1'b1;
            default:      ;
        endcase
    end

    assign halt_req_o = halt_q;
    assign wake_o     = |(key_s_i & ~key_q);

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !halt_ack_i) |=> halt_q);
    p_off_no_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (power_off_o && !halt_q) |=> !halt_q);
    p_reset_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_o |=> !cpu_reset_o && !power_off_o);
    p_off_no_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_OFF_WAIT) |=> !cpu_reset_o);
endmodule

// File: rtl/pic_unit.sv
module pic_unit
    import pic_pkg::*;
#(
    parameter int          KEY_W       = 11,
    parameter int          SYNC_STAGES = 2,
    parameter int          FILTER_LEN  = 2,
    parameter int          DIV_RATIO   = 8,
    parameter logic [15:0] CSR_ADDR    = 16'h0104
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_sel_i,
    input  logic             bus_we_i,
    input  logic [15:0]      bus_addr_i,
    input  logic [15:0]      bus_wdata_i,
    output logic [15:0]      bus_rdata_o,
    input  logic [KEY_W-1:0] key_col_i,
    input  logic             port_pin1_i,
    input  logic             int_mask_i,
    input  logic             halt_ack_i,
    input  logic             evt_ack_i,
    output logic [3:0]       grp_dir_o,
    output logic [4:0]       mem_cfg_o,
    output logic             clk_run_o,
    output logic             clk_fast_o,
    output logic             pwr_down_o,
    output logic             cpu_clk_en_o,
    output logic             halt_req_o,
    output logic             evt_req_o,
    output logic             power_off_o,
    output logic             cpu_reset_o,
    output logic             wake_o
);
    logic [KEY_W-1:0] key_s;
    logic             pin_s, pin_low, pin_low_q, evt_q, evt_set;
    logic [CSR_W-1:0] csr;

    pic_sync #(.W(KEY_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_key_sync (
        .clk(clk_i), .rst_n(rst_ni), .d_i(key_col_i), .q_o(key_s));

    pic_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk_i), .rst_n(rst_ni), .d_i(port_pin1_i), .q_o(pin_s));

    pic_lowfilt #(.LEN(FILTER_LEN)) u_filt (
        .clk(clk_i), .rst_n(rst_ni), .pin_s_i(pin_s), .low_o(pin_low));

    pic_csr #(.CSR_ADDR(CSR_ADDR)) u_csr (
        .clk(clk_i), .rst_n(rst_ni), .sel_i(bus_sel_i), .we_i(bus_we_i),
        .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .capture_i(pin_low),
        .rdata_o(bus_rdata_o), .csr_o(csr));

    pic_pwr_fsm #(.KEY_W(KEY_W)) u_fsm (
        .clk(clk_i), .rst_n(rst_ni), .key_s_i(key_s), .halt_ack_i(halt_ack_i),
        .halt_req_o(halt_req_o), .power_off_o(power_off_o),
        .cpu_reset_o(cpu_reset_o), .wake_o(wake_o));

    pic_clkdiv #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk(clk_i), .rst_n(rst_ni), .run_i(csr[RUN_BIT]), .fast_i(csr[FAST_BIT]),
        .hold_i(power_off_o), .clk_en_o(cpu_clk_en_o));

    assign evt_set = pin_low && !pin_low_q && !int_mask_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_low_q <= 1'b0;
            evt_q     <= 1'b0;
        end else begin
            pin_low_q <= pin_low;
            if (evt_set)        evt_q <= 1'b1;
            else if (evt_ack_i) evt_q <= 1'b0;
        end
    end

    assign evt_req_o  = evt_q;
    assign grp_dir_o  = csr[DIR_LSB +: DIR_W];
    assign mem_cfg_o  = csr[MEM_LSB +: MEM_W];
    assign clk_run_o  = csr[RUN_BIT];
    assign clk_fast_o = csr[FAST_BIT];
    assign pwr_down_o = csr[PDN_BIT];

    p_evt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_q && !evt_ack_i) |=> evt_q);
    p_evt_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!evt_q && int_mask_i) |=> !evt_q);
    p_flag_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_low |=> csr[FLAG_BIT]);
    p_off_gates_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        power_off_o |-> !cpu_clk_en_o);
endmodule

// File: tb/pic_unit_bench.sv
`timescale 1ns/1ps
module pic_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        sel = 0, we = 0;
    logic [15:0] addr = 0, wdata = 0;
    logic [15:0] rdata;
    logic [10:0] keys = '1;
    logic        pin = 1, mask = 1, hack = 0, eack = 0;
    logic [3:0]  dir;
    logic [4:0]  mem;
    logic        run, fast, pdn, cen, halt, evt, poff, creset, wake;

    int n_vec = 0, n_bad = 0;
    int cen_cnt = 0, wake_cnt = 0, rst_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pic_unit u_pic_unit (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .key_col_i(keys), .port_pin1_i(pin), .int_mask_i(mask),
        .halt_ack_i(hack), .evt_ack_i(eack), .grp_dir_o(dir), .mem_cfg_o(mem),
        .clk_run_o(run), .clk_fast_o(fast), .pwr_down_o(pdn),
        .cpu_clk_en_o(cen), .halt_req_o(halt), .evt_req_o(evt),
        .power_off_o(poff), .cpu_reset_o(creset), .wake_o(wake));

    always @(negedge clk) begin
        if (rst_n) begin
            if (cen)    cen_cnt++;
            if (wake)   wake_cnt++;
            if (creset) rst_cnt++;
        end
    end

    function automatic logic [15:0] model_wr(input logic [15:0] d);
        return d & 16'h1FEF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; we = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        sel = 1; we = 0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 0;
    endtask

    task automatic pulse_ack(input bit which_halt);
        @(negedge clk);
        if (which_halt) hack = 1; else eack = 1;
        @(negedge clk);
        hack = 0; eack = 0;
    endtask

    task automatic window(input int n, output int cnt);
        int s;
        s = cen_cnt;
        idle(n);
        cnt = cen_cnt - s;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [15:0] d, m;
        int c, w0;
        void'($urandom(32'h00C0FFEE));
        idle(3);
        rst_n = 1;
        idle(4);

        rd(16'h0104, d);
        check("R1 reset value", d, 16'h0C0F);
        check("R1 outputs", {dir, mem, run, fast, pdn}, {4'hF, 5'h0, 1'b1, 1'b1, 1'b0});
        check("R5 no halt at reset", {halt, evt, poff}, 3'b000);

        wr(16'h0104, 16'hFFFF);
        rd(16'h0104, d);
        check("R2 all ones, R1 top bits zero", d, 16'h1FEF);

        for (int i = 0; i < 40; i++) begin
            d = 16'($urandom);
            if (i % 4 == 3) begin
                rd(16'h0104, m);
                wr(16'h0106 + 16'(2 * ($urandom % 50)), d);
                rd(16'h0104, w0[15:0]);
                check("R10 foreign write ignored", w0[15:0], m);
                rd(16'h0100, m);
                check("R10 foreign read zero", m, 16'h0000);
            end else begin
                wr(16'h0104, d);
                rd(16'h0104, m);
                check("R2 readback", m, model_wr(d));
                check("R2 fields", {dir, mem, run, fast, pdn},
                      {d[3:0], d[9:5], d[10], d[11], d[12]});
            end
        end

        wr(16'h0104, 16'h040F);
        window(64, c);
        check("R9 divided enables", c, 8);
        wr(16'h0104, 16'h0C0F);
        window(64, c);
        check("R9 full speed enables", c, 64);
        wr(16'h0104, 16'h080F);
        window(64, c);
        check("R9 stopped", c, 0);
        wr(16'h0104, 16'h0C0F);

        @(negedge clk) pin = 0;
        @(negedge clk) pin = 1;
        idle(6);
        rd(16'h0104, d);
        check("R3 single low ignored", d[4], 1'b0);
        mask = 1;
        @(negedge clk) pin = 0;
        idle(3);
        @(negedge clk) pin = 1;
        idle(6);
        rd(16'h0104, d);
        check("R3 flag set", d[4], 1'b1);
        check("R4 masked no event", evt, 1'b0);
        wr(16'h0104, 16'h0C1E);
        rd(16'h0104, d);
        check("R3 write clears flag", d, 16'h0C0E);
        mask = 0;
        @(negedge clk) pin = 0;
        idle(4);
        @(negedge clk) pin = 1;
        idle(6);
        check("R4 event raised", evt, 1'b1);
        idle(5);
        check("R4 event held", evt, 1'b1);
        pulse_ack(0);
        idle(2);
        check("R4 event acked", evt, 1'b0);
        rd(16'h0104, d);
        check("R3 flag with output group", d[4], 1'b1);
        wr(16'h0104, 16'h0C0F);
        mask = 1;

        w0 = wake_cnt;
        for (int i = 0; i < 30; i++) begin
            m = keys;
            keys = 11'($urandom) | 11'b110_0000_0011;
            idle(5);
            if (|(keys & ~m[10:0])) w0++;
        end
        keys = '1;
        idle(5);
        if (|(~m[10:0] & keys)) w0 += 0;
        c = wake_cnt;
        check("R8 wake count random", 32'(c) - 32'(w0) <= 1 ? 1 : 0, 1);
        w0 = wake_cnt;
        @(negedge clk) keys[4] = 0;
        idle(5);
        check("R8 press gives no wake", wake_cnt - w0, 0);
        keys[4] = 1;
        idle(5);
        check("R8 release wakes once", wake_cnt - w0, 1);
        check("R5 no halt from random keys", halt, 1'b0);

        keys[9] = 0; keys[10] = 0;
        idle(6);
        check("R5 halt on 9/10", halt, 1'b1);
        pulse_ack(1);
        idle(3);
        check("R5 halt acked while held", halt, 1'b0);
        keys = '1;
        idle(5);
        keys[0] = 0; keys[10] = 0;
        idle(6);
        check("R5 halt on 0/10", halt, 1'b1);
        pulse_ack(1);
        keys = '1;
        idle(5);

        c = rst_cnt;
        keys[0] = 0; keys[1] = 0;
        idle(6);
        check("R6 power off", poff, 1'b1);
        window(16, w0);
        check("R6 clock gated", w0, 0);
        keys = '1;
        idle(8);
        check("R6 stays off", {poff, halt}, 2'b10);
        keys[9] = 0; keys[10] = 0;
        idle(6);
        check("R6 held still off", {poff, halt, 32'(rst_cnt - c)}, {2'b10, 32'd0});
        keys[9] = 1;
        idle(6);
        check("R7 one reset pulse", rst_cnt - c, 1);
        check("R7 running again", {poff, halt}, 2'b00);
        keys = '1;
        idle(4);
        keys[0] = 0; keys[10] = 0;
        idle(6);
        check("R7 halt after restart", halt, 1'b1);
        pulse_ack(1);
        keys = '1;
        idle(6);
        check("R7 no extra reset", rst_cnt - c, 1);

        summary();
    end
endmodule